// File: doc/BRIEF.md
# Interrupt Request Capture Latch

This block turns up to eight raw interrupt request lines into a pending-request vector. For each line, a trigger-mode bit chooses the capture rule. In level mode the pending bit copies the line. In edge mode the pending bit is set by a low-to-high transition and then holds until it is acknowledged. A separate register keeps the level each line had on the previous clock, and the edge detector compares against it.

Software loads the trigger-mode register through a write strobe and data word. A constant, fixed for each instance, filters that data so that only implemented bits can ever become level-triggered. The acknowledge strobe names one line by index. It clears that line only when the line is edge-triggered. Level requests stay pending for as long as their input is high.

Every output is registered and updates on the rising edge of the clock. The mask input does not stop a request from being captured. It only stops the request from being announced as a new one.

Top module: `irql_top`

## Requirements
- R1: With its trigger-mode bit at 1 (level), a line's pending bit takes the input value sampled at the previous rising edge, whether that value is high or low.
- R2: With its trigger-mode bit at 0 (edge), a line's pending bit is set one cycle after the input is sampled high while the previously sampled level was low.
- R3: An edge-mode pending bit stays set while the input is low, and an input held high does not set it again.
- R4: When acknowledge is asserted with index n, and line n is in edge mode, pending bit n clears on the next edge. When line n is in level mode the acknowledge has no effect. No other line is affected either way.
- R5: When the write strobe is asserted, the trigger-mode output becomes the write data ANDed with the instance's writable mask on the next edge. Without a write the register keeps its value.
- R6: A new-request bit pulses for one cycle when a pending bit goes from 0 to 1, but only if that line's mask bit was 0 at that edge. A masked line still sets its pending bit.
- R7: Synchronous active-high reset clears the pending bits, the previous-level bits, the new-request bits and the trigger-mode register.
- R8: If acknowledge and a fresh rising edge reach the same edge-mode line in the same cycle, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_LINES | Raw request levels, already synchronous to clk |
| mask_i | input | NUM_LINES | Per-line mask, 1 suppresses the new-request pulse |
| ack_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | IDXW | Index of the line being acknowledged |
| tm_wr_i | input | 1 | Trigger-mode register write strobe |
| tm_wdata_i | input | NUM_LINES | Trigger-mode write data, 1 selects level |
| tm_o | output | NUM_LINES | Current trigger-mode register |
| pend_o | output | NUM_LINES | Pending request vector |
| new_o | output | NUM_LINES | One-cycle new-request indication per line |

## Verification
The bench builds two instances side by side and drives them with the same stimulus. One uses the writable mask 0xF8, so lines 0 to 2 are always edge-triggered. The other uses 0xDE, so lines 0 and 5 are always edge-triggered. Together they cover mixed edge/level vectors in two different layouts and show that writes to fixed bits are ignored. Directed sequences cover acknowledge on a level line, acknowledge colliding with an edge, and masked capture. Random traffic then changes trigger modes while requests are in flight.

// File: rtl/irql_pkg.sv
package irql_pkg;
  localparam int unsigned DEF_LINES = 8;
  localparam logic [7:0] WMASK_PRIMARY   = 8'hF8;
  localparam logic [7:0] WMASK_SECONDARY = 8'hDE;
  typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/irql_mode_reg.sv
module irql_mode_reg #(
  parameter int unsigned          NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] WR_MASK   = '1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] mode_o
);
  logic [NUM_LINES-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst)       mode_q <= '0;
    else if (wr_i) mode_q <= wdata_i & WR_MASK;
  end

  assign mode_o = mode_q;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> $stable(mode_o)); // R5
  AST_MODE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    wr_i |=> ((mode_o & ~$past(wdata_i)) == '0)); // R5
endmodule

// File: rtl/irql_ack_dec.sv
module irql_ack_dec #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 ack_i,
  input  logic [IDXW-1:0]      idx_i,
  output logic [NUM_LINES-1:0] hit_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
    assign hit_o[i] = ack_i && (idx_i == IDXW'(i));
  end
endmodule

// File: rtl/irql_line.sv
module irql_line (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic mode_i,
  input  logic mask_i,
  input  logic ack_hit_i,
  output logic pend_o,
  output logic new_o
);
  import irql_pkg::*;

  logic pend_q, last_q, new_q;
  logic rise, pend_d;

  always_comb begin
    rise = req_i & ~last_q;
    if (mode_i == TRIG_LEVEL) pend_d = req_i;
    else if (rise)            pend_d = 1'b1;
    else if (ack_hit_i)       pend_d = 1'b0;
    else                      pend_d = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
      new_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      last_q <= req_i;
      new_q  <= pend_d & ~pend_q & ~mask_i;
    end
  end

  assign pend_o = pend_q;
  assign new_o  = new_q;

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (rst)
    mode_i |=> (pend_q == $past(req_i))); // R1
  AST_EDGE_RISE_SET: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && req_i && !last_q) |=> pend_q); // R2
  AST_EDGE_LOW_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && !req_i && pend_q && !ack_hit_i) |=> pend_q); // R3
  AST_ACK_EDGE_CLR: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && ack_hit_i && !(req_i && !last_q)) |=> !pend_q); // R4
  AST_MASK_NO_NEW: assert property (@(posedge clk) disable iff (rst)
    mask_i |=> !new_q); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!pend_q && !new_q)); // R7
  AST_ACK_RISE_WINS: assert property (@(posedge clk) disable iff (rst)
    (!mode_i && ack_hit_i && req_i && !last_q) |=> pend_q); // R8
endmodule

// File: rtl/irql_top.sv
module irql_top #(
  parameter int unsigned          NUM_LINES = irql_pkg::DEF_LINES,
  parameter logic [NUM_LINES-1:0] WR_MASK   = irql_pkg::WMASK_PRIMARY,
  localparam int unsigned IDXW = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic                 ack_i,
  input  logic [IDXW-1:0]      ack_idx_i,
  input  logic                 tm_wr_i,
  input  logic [NUM_LINES-1:0] tm_wdata_i,
  output logic [NUM_LINES-1:0] tm_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] new_o
);
  logic [NUM_LINES-1:0] mode;
  logic [NUM_LINES-1:0] ack_hit;

  irql_mode_reg #(.NUM_LINES(NUM_LINES), .WR_MASK(WR_MASK)) u_mode (
    .clk(clk), .rst(rst), .wr_i(tm_wr_i), .wdata_i(tm_wdata_i), .mode_o(mode)
  );

  irql_ack_dec #(.NUM_LINES(NUM_LINES)) u_ack (
    .ack_i(ack_i), .idx_i(ack_idx_i), .hit_o(ack_hit)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irql_line u_line (
      .clk(clk), .rst(rst), .req_i(req_i[i]), .mode_i(mode[i]),
      .mask_i(mask_i[i]), .ack_hit_i(ack_hit[i]),
      .pend_o(pend_o[i]), .new_o(new_o[i])
    );
  end

  assign tm_o = mode;

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_hit)); // R4
endmodule

// File: tb/irql_top_tb_top.sv
module irql_top_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req = '0, mask = '0, wdata = '0;
  logic       ack = 1'b0, wr = 1'b0;
  logic [2:0] idx = '0;
  logic [7:0] tm_w [2];
  logic [7:0] pend_w [2];
  logic [7:0] new_w [2];

  logic [7:0] m_pend [2];
  logic [7:0] m_last [2];
  logic [7:0] m_tm [2];
  logic [7:0] m_new [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irql_top #(.NUM_LINES(8), .WR_MASK(8'hF8)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .ack_i(ack),
    .ack_idx_i(idx), .tm_wr_i(wr), .tm_wdata_i(wdata),
    .tm_o(tm_w[0]), .pend_o(pend_w[0]), .new_o(new_w[0])
  );

  irql_top #(.NUM_LINES(8), .WR_MASK(8'hDE)) dut_sec_i (
    .clk(clk), .rst(rst), .req_i(req), .mask_i(mask), .ack_i(ack),
    .ack_idx_i(idx), .tm_wr_i(wr), .tm_wdata_i(wdata),
    .tm_o(tm_w[1]), .pend_o(pend_w[1]), .new_o(new_w[1])
  );

  function automatic logic [7:0] wmask(input int k);
    return (k == 0) ? 8'hF8 : 8'hDE;
  endfunction

  // Expected next state from R1..R8
  task automatic model_step();
    for (int k = 0; k < 2; k++) begin
      logic [7:0] np, nt;
      if (rst) begin
        m_pend[k] = '0; m_last[k] = '0; m_tm[k] = '0; m_new[k] = '0;
      end else begin
        nt = wr ? (wdata & wmask(k)) : m_tm[k];
        for (int i = 0; i < 8; i++) begin
          if (m_tm[k][i])                     np[i] = req[i];
          else if (req[i] && !m_last[k][i])   np[i] = 1'b1;
          else if (ack && idx == 3'(i))       np[i] = 1'b0;
          else                                np[i] = m_pend[k][i];
        end
        m_new[k]  = np & ~m_pend[k] & ~mask;
        m_pend[k] = np;
        m_last[k] = req;
        m_tm[k]   = nt;
      end
    end
  endtask

  task automatic chk(input string tag, input string what, input int k,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s inst%0d actual=%h expected=%h", tag, what, k, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "pend", k, pend_w[k], m_pend[k]);
      chk(tag, "new",  k, new_w[k],  m_new[k]);
      chk(tag, "tm",   k, tm_w[k],   m_tm[k]);
    end
  endtask

  task automatic setin(input logic [7:0] r, input logic [7:0] m, input logic a,
                       input logic [2:0] ix, input logic w, input logic [7:0] wd);
    req = r; mask = m; ack = a; idx = ix; wr = w; wdata = wd;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    @(negedge clk);
    cycle("R7 reset");
    cycle("R7 reset held");
    rst = 1'b0;
    cycle("R7 after reset");
    setin(8'h00, 8'h00, 0, 0, 1, 8'hFF); cycle("R5 write filtered");
    setin(8'h00, 8'h00, 0, 0, 0, 8'h00); cycle("R5 no write holds");
    setin(8'h09, 8'h00, 0, 0, 0, 8'h00); cycle("R1 R2 raise edge and level");
    setin(8'h01, 8'h00, 0, 0, 0, 8'h00); cycle("R1 level drop R3 high held");
    setin(8'h00, 8'h00, 0, 0, 0, 8'h00); cycle("R3 edge low keeps");
    setin(8'h00, 8'h00, 1, 0, 0, 8'h00); cycle("R4 ack edge clears");
    setin(8'h08, 8'h00, 0, 0, 0, 8'h00); cycle("R1 level set");
    setin(8'h08, 8'h00, 1, 3, 0, 8'h00); cycle("R4 ack level ignored");
    setin(8'h01, 8'h01, 0, 0, 0, 8'h00); cycle("R6 masked still latches");
    setin(8'h00, 8'h00, 0, 0, 0, 8'h00); cycle("R3 hold");
    setin(8'h01, 8'h00, 1, 0, 0, 8'h00); cycle("R8 ack with new edge");
    setin(8'h00, 8'h00, 0, 0, 0, 8'h00); cycle("R8 still pending");
    for (int n = 0; n < 3000; n++) begin
      setin(req ^ (8'($urandom) & 8'($urandom)), 8'($urandom),
            ($urandom % 3) == 0, 3'($urandom), ($urandom % 16) == 0,
            8'($urandom));
      if (n == 1500) rst = 1'b1;
      else rst = 1'b0;
      cycle("R1 R2 R3 R4 R5 R6 R7 R8 random");
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule